// File: doc/BRIEF.md
# Byte-Lane Write SRAM Core

A synchronous single-port memory, 32 bits wide, meant to serve as the data store of a cache. Each cycle carries one command: a read, or a write that may touch any subset of the four byte lanes. An active-low global write input forces a write of the whole word. When it is inactive, an active-low byte-write enable hands control to four active-low lane strobes. With that enable inactive, the cycle is a read.

A mode input picks one of two timings. In flow-through mode, address, command, strobes and write data are all taken on one clock edge. Read data leaves a register on that same edge. In pipelined mode, the address and command are registered on one edge. The write data and the lane strobes are then taken on the following edge, and the array is updated on that edge. A read in this mode returns data one edge later than in flow-through mode. Burst address sequencing lives outside this block.

Top module: `bwsram_core`

## Requirements
- R1: With `gwr_n` low, all four lanes of the addressed word are written, whatever `bwen_n` and `bstb_n` hold.
- R2: With `gwr_n` high and `bwen_n` high, the cycle is a read: no lane is written, whatever `bstb_n` and `wdata` hold.
- R3: With `gwr_n` high and `bwen_n` low, lane i is written exactly when `bstb_n[i]` is low. Lane 0 is `wdata[7:0]`, lane 1 is `[15:8]`, lane 2 is `[23:16]` and lane 3 is `[31:24]`. The other lanes keep their contents.
- R4: With `gwr_n` high, `bwen_n` low and `bstb_n` = 4'b1111, nothing is written and the cycle acts as a read.
- R5: With `gwr_n` high, `bwen_n` low and `bstb_n` = 4'b0000, the whole word is written, the same as R1.
- R6: With `pipe_mode` low, address, command, strobes and data are sampled on one rising edge. A read's data is on `rdata` right after that edge, and a write on edge N is seen by a read on edge N+1.
- R7: With `pipe_mode` high, the address and command are taken on edge N. The lane strobes and write data are taken on edge N+1, where the write lands. Strobes present on edge N have no effect on that write.
- R8: With `pipe_mode` high, a read whose address is taken on edge N updates `rdata` on edge N+1, and `rdata` does not change on edge N.
- R9: `rdata` changes only on a read; write cycles leave it as it was.
- R10: Synchronous active-high `rst` clears `rdata` to zero and drops any half-finished pipelined command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pipe_mode | input | 1 | 1 selects pipelined timing, 0 flow-through |
| gwr_n | input | 1 | Global write, active low, writes all lanes |
| bwen_n | input | 1 | Byte-write enable, active low |
| bstb_n | input | 4 | Per-lane write strobes, active low, bit i is byte lane i |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The bench builds the core with `ADDR_W = 4`, a 16-word array. At that size every word is filled before it is read, and both the lowest and the highest index can be reached in a short run. Every one of the sixteen strobe patterns is tried in both timing modes against a word-level reference. In pipelined mode, the strobes on the address edge are deliberately set to a different pattern from the strobes on the data edge, so a core that uses the wrong strobes shows up.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef logic [LANES-1:0] lane_mask_t;

    typedef struct packed {
        logic glob_n;
        logic bwe_n;
    } wr_ctl_t;

    localparam wr_ctl_t CTL_IDLE = '{glob_n: 1'b1, bwe_n: 1'b1};

    // Lanes to write for a command and a set of active-low strobes.
    function automatic lane_mask_t lane_select(wr_ctl_t c, lane_mask_t stb_n);
        if (!c.glob_n)
            return '1;
        else if (!c.bwe_n)
            return ~stb_n;
        else
            return '0;
    endfunction

endpackage

// File: rtl/bwsram_cmd_stage.sv
module bwsram_cmd_stage
    import bwsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_mode,
    input  wr_ctl_t           ctl_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              eff_vld,
    output wr_ctl_t           eff_ctl,
    output logic [ADDR_W-1:0] eff_addr
);

    logic              a_vld;
    wr_ctl_t           a_ctl;
    logic [ADDR_W-1:0] a_addr;

    // Address stage: holds a command only while pipelined timing is selected.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_vld  <= 1'b0;
            a_ctl  <= CTL_IDLE;
            a_addr <= '0;
        end else begin
            a_vld  <= pipe_mode;
            a_ctl  <= ctl_in;
            a_addr <= addr_in;
        end
    end

    always_comb begin
        if (pipe_mode) begin
            eff_vld  = a_vld;
            eff_ctl  = a_ctl;
            eff_addr = a_addr;
        end else begin
            eff_vld  = 1'b1;
            eff_ctl  = ctl_in;
            eff_addr = addr_in;
        end
    end

endmodule

// File: rtl/bwsram_lane_dec.sv
module bwsram_lane_dec
    import bwsram_pkg::*;
(
    input  logic       vld,
    input  wr_ctl_t    ctl,
    input  lane_mask_t stb_n,
    output lane_mask_t lane_we,
    output logic       rd_en
);

    always_comb begin
        lane_we = vld ? lane_select(ctl, stb_n) : '0;
        rd_en   = vld && (lane_we == '0);
    end

endmodule

// File: rtl/bwsram_array.sv
module bwsram_array
    import bwsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  lane_mask_t        lane_we,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (lane_we[g])
                store[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (rst)
                rd_q <= '0;
            else if (rd_en)
                rd_q <= store[addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/bwsram_core.sv
module bwsram_core
    import bwsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_mode,
    input  logic              gwr_n,
    input  logic              bwen_n,
    input  logic [3:0]        bstb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);

    wr_ctl_t           ctl_in;
    logic              eff_vld;
    wr_ctl_t           eff_ctl;
    logic [ADDR_W-1:0] eff_addr;
    lane_mask_t        lane_we;
    logic              rd_en;

    assign ctl_in = '{glob_n: gwr_n, bwe_n: bwen_n};

    bwsram_cmd_stage #(.ADDR_W(ADDR_W)) i_cmd (
        .clk      (clk),
        .rst      (rst),
        .pipe_mode(pipe_mode),
        .ctl_in   (ctl_in),
        .addr_in  (addr),
        .eff_vld  (eff_vld),
        .eff_ctl  (eff_ctl),
        .eff_addr (eff_addr)
    );

    bwsram_lane_dec i_dec (
        .vld    (eff_vld && !rst),
        .ctl    (eff_ctl),
        .stb_n  (bstb_n),
        .lane_we(lane_we),
        .rd_en  (rd_en)
    );

    bwsram_array #(.ADDR_W(ADDR_W)) i_arr (
        .clk    (clk),
        .rst    (rst),
        .lane_we(lane_we),
        .rd_en  (rd_en),
        .addr   (eff_addr),
        .wdata  (wdata),
        .rdata  (rdata)
    );

endmodule

// File: rtl/bwsram_chk.sv
module bwsram_chk (
    input logic        clk,
    input logic        rst,
    input logic        pipe_mode,
    input logic        gwr_n,
    input logic        bwen_n,
    input logic [3:0]  bstb_n,
    input logic [3:0]  lane_we,
    input logic [31:0] rdata
);

    p_glob_all_r1: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && !gwr_n) |-> lane_we == 4'hF);

    p_read_none_r2: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && gwr_n && bwen_n) |-> lane_we == 4'h0);

    p_lane_map_r3: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && gwr_n && !bwen_n) |-> lane_we == ~bstb_n);

    p_no_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && gwr_n && !bwen_n && bstb_n == 4'hF) |-> lane_we == 4'h0);

    p_pipe_glob_r7: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && $past(pipe_mode) && !$past(rst) && !$past(gwr_n))
            |-> lane_we == 4'hF);

    p_pipe_late_stb_r7: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && $past(pipe_mode) && !$past(rst) && $past(gwr_n) && !$past(bwen_n))
            |-> lane_we == ~bstb_n);

    p_pipe_read_r8: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && $past(pipe_mode) && !$past(rst) && $past(gwr_n) && $past(bwen_n))
            |-> lane_we == 4'h0);

    p_wr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && !gwr_n) |=> $stable(rdata));

endmodule

bind bwsram_core bwsram_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .pipe_mode(pipe_mode),
    .gwr_n    (gwr_n),
    .bwen_n   (bwen_n),
    .bstb_n   (bstb_n),
    .lane_we  (lane_we),
    .rdata    (rdata)
);

// File: tb/test_bwsram_core.sv
module test_bwsram_core;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pipe_mode = 1'b0;
    logic          gwr_n = 1'b1;
    logic          bwen_n = 1'b1;
    logic [3:0]    bstb_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0]   ref_mem [DEPTH];
    logic [31:0]   exp_rd;
    logic          p_pm, p_g, p_b;
    logic [AW-1:0] p_a;

    always #5 clk = ~clk;

    bwsram_core #(.ADDR_W(AW)) i_bwsram_core (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .gwr_n(gwr_n),
        .bwen_n(bwen_n), .bstb_n(bstb_n), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [3:0] lanes_of(logic g, logic b, logic [3:0] s);
        if (!g) return 4'hF;
        if (!b) return ~s;
        return 4'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s rdata=%h expected=%h", tag, got, want);
        end
    endtask

    // Called at a falling edge: drive, cross one rising edge, update the model, check.
    task automatic step(input logic pm, input logic g, input logic b, input logic [3:0] s,
                        input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        logic          v;
        logic [3:0]    m;
        logic [AW-1:0] wa;
        pipe_mode = pm; gwr_n = g; bwen_n = b; bstb_n = s; addr = a; wdata = d;
        @(posedge clk);
        v = 1'b0; m = 4'h0; wa = a;
        if (!pm) begin
            v = 1'b1; m = lanes_of(g, b, s); wa = a;
        end else if (p_pm) begin
            v = 1'b1; m = lanes_of(p_g, p_b, s); wa = p_a;
        end
        if (v && m == 4'h0) exp_rd = ref_mem[wa];
        if (v)
            for (int i = 0; i < 4; i++)
                if (m[i]) ref_mem[wa][i*8 +: 8] = d[i*8 +: 8];
        p_pm = pm; p_g = g; p_b = b; p_a = a;
        @(negedge clk);
        check(tag, rdata, exp_rd);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        p_pm = 1'b0; p_g = 1'b1; p_b = 1'b1; p_a = '0; exp_rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10", rdata, 32'h0);
    endtask

    task automatic t_fill();
        for (int a = 0; a < DEPTH; a++)
            step(1'b0, 1'b0, 1'b1, 4'h5, a[AW-1:0], 32'h1000_0000 + a * 32'h0101_0101, "R1");
        for (int a = 0; a < DEPTH; a++)
            step(1'b0, 1'b1, 1'b1, 4'h0, a[AW-1:0], 32'hDEAD_BEEF, "R6");
    endtask

    task automatic t_flow_global();
        step(1'b0, 1'b0, 1'b0, 4'hF, 4'd2, 32'hCAFE_F00D, "R1");
        step(1'b0, 1'b1, 1'b1, 4'hF, 4'd2, 32'h0, "R1");
        step(1'b0, 1'b0, 1'b0, 4'hA, 4'(DEPTH-1), 32'h7788_99AA, "R1");
        step(1'b0, 1'b1, 1'b1, 4'hF, 4'(DEPTH-1), 32'h0, "R1");
    endtask

    task automatic t_flow_read();
        step(1'b0, 1'b1, 1'b1, 4'h0, 4'd2, 32'hFFFF_FFFF, "R2");
        step(1'b0, 1'b1, 1'b1, 4'h3, 4'd2, 32'h1234_5678, "R2");
        step(1'b0, 1'b1, 1'b1, 4'hF, 4'd0, 32'h0, "R2");
    endtask

    task automatic t_flow_lanes();
        for (int k = 0; k < 16; k++) begin
            string tg;
            tg = (k == 15) ? "R4" : (k == 0) ? "R5" : "R3";
            step(1'b0, 1'b0, 1'b1, 4'hF, 4'd3, 32'h0000_0000, tg);
            step(1'b0, 1'b1, 1'b0, k[3:0], 4'd3, 32'hA1B2_C3D4 ^ k, tg);
            step(1'b0, 1'b1, 1'b1, 4'hF, 4'd3, 32'h0, tg);
        end
    endtask

    task automatic t_flow_timing();
        step(1'b0, 1'b0, 1'b1, 4'hF, 4'd7, 32'h0BAD_CAFE, "R6");
        step(1'b0, 1'b1, 1'b1, 4'hF, 4'd7, 32'h0, "R6");
        step(1'b0, 1'b0, 1'b1, 4'hF, 4'd8, 32'h5555_AAAA, "R9");
        step(1'b0, 1'b1, 1'b0, 4'h6, 4'd9, 32'h3333_CCCC, "R9");
        step(1'b0, 1'b0, 1'b1, 4'hF, 4'd7, 32'h1111_2222, "R9");
        step(1'b0, 1'b1, 1'b1, 4'hF, 4'd9, 32'h0, "R3");
    endtask

    task automatic t_pipe();
        // Drop into pipelined timing with a read in flight.
        step(1'b1, 1'b1, 1'b1, 4'hF, 4'd5, 32'h0, "R8");
        step(1'b1, 1'b1, 1'b1, 4'hF, 4'd5, 32'h0, "R8");
        for (int k = 0; k < 16; k++) begin
            logic [3:0] late;
            late = k[3:0];
            // Address edge: byte write command, misleading strobes.
            step(1'b1, 1'b1, 1'b0, ~late, 4'd5, 32'hFFFF_FFFF, "R7");
            // Data edge: real strobes and data; the command here is a read of the same word.
            step(1'b1, 1'b1, 1'b1, late, 4'd5, 32'h9000_0000 + k * 32'h0011_2233, "R7");
            step(1'b1, 1'b1, 1'b1, 4'h0, 4'd6, 32'h0, "R8");
        end
        // Global write in pipelined timing with all strobes high on the data edge.
        step(1'b1, 1'b0, 1'b1, 4'h0, 4'd4, 32'h0, "R1");
        step(1'b1, 1'b1, 1'b1, 4'hF, 4'd4, 32'hFEED_0001, "R1");
        step(1'b1, 1'b1, 1'b1, 4'hF, 4'(DEPTH-1), 32'h0, "R8");
        step(1'b1, 1'b1, 1'b1, 4'hF, 4'd0, 32'h0, "R8");
        // Back to flow-through and confirm the stored words.
        step(1'b0, 1'b1, 1'b1, 4'hF, 4'd4, 32'h0, "R6");
        step(1'b0, 1'b1, 1'b1, 4'hF, 4'd5, 32'h0, "R6");
    endtask

    task automatic t_reset_drop();
        // Pipelined write command, then reset before its data edge.
        step(1'b1, 1'b0, 1'b1, 4'hF, 4'd1, 32'h0, "R10");
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        p_pm = 1'b0; exp_rd = '0;
        check("R10", rdata, 32'h0);
        step(1'b1, 1'b1, 1'b1, 4'h0, 4'd1, 32'h6666_6666, "R10");
        step(1'b0, 1'b1, 1'b1, 4'hF, 4'd1, 32'h0, "R10");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fill();
        t_flow_global();
        t_flow_read();
        t_flow_lanes();
        t_flow_timing();
        t_pipe();
        t_reset_drop();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired rdata=%h expected=run end", rdata);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule